// File: doc/BRIEF.md
# Byte-Lane Parity Error Capture Unit

This block sits beside a 32-bit memory data path. On every memory write it produces one odd-parity bit for each of the four byte lanes. On every memory read it checks the four stored parity bits against the data that comes back. The first read that shows a mismatch is recorded: which lanes failed, plus the virtual address, context number and bus-master source of that cycle. The record then stays frozen and a non-maskable interrupt request stays raised until software releases it.

Software reaches the block through a small register port with two registers. The control byte holds three writable bits: interrupt enable, a test bit and check enable. It also holds four read-only lane error flags and a read-only pending bit. The error address register returns the captured cycle information. A write that includes its top byte clears the record and re-arms capture. With the test bit set, writes store inverted parity on purpose, so that software can plant a fault and read it back to exercise the error path.

Top module: `mem_parity_guard`

## Requirements
- R1: On a write cycle (`cyc_valid`=1, `cyc_write`=1), `wr_par[i]` becomes the inverted XOR of `wr_data[8*i+7:8*i]`, so each lane has odd parity. The value appears after the clock edge that takes the write and holds until the next write.
- R2: While the test bit (control bit 5) is set, every `wr_par` bit produced by a write is the inverse of the value in R1.
- R3: A read cycle (`cyc_valid`=1, `cyc_write`=0) is checked only while check enable (control bit 4) is set. Lane i fails when `rd_par[i]` differs from the inverted XOR of its data byte. Lane error flag i sits in control bit i: bit 0 covers data bits 7..0 and bit 3 covers data bits 31..24.
- R4: The first failing read sets every failing lane's flag in one capture. It also loads the error address register as {dvma flag in bit 31, context in bits 30..28, virtual address in bits 27..0}.
- R5: While a capture is held, later failing reads change neither the flags nor the error address register.
- R6: A register write (`reg_we`=1, `reg_sel`=1) with `reg_be[3]`=1 clears the flags and the error address register after the edge that takes it. Writes to that register with `reg_be[3]`=0 have no effect.
- R7: `nmi_req` and pending bit 7 are 1 exactly while a capture is held and interrupt enable (control bit 6) is set.
- R8: Control writes (`reg_we`=1, `reg_sel`=0) update only bits 6..4 from `reg_wdata[6:4]`. Bits 7 and 3..0 ignore them.
- R9: A failing read on the same cycle as a clearing write is not lost. The flags read zero for one cycle, and then that read's capture appears.
- R10: After reset, both registers read zero, and `nmi_req` and `wr_par` are 0.
- R11: `reg_rdata` is registered. After each edge it shows the register chosen by `reg_sel` (0 for control, 1 for error address) as it stood before that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cyc_valid | input | 1 | Memory cycle strobe |
| cyc_write | input | 1 | 1 for a write cycle, 0 for a read cycle |
| cyc_vaddr | input | 28 | Virtual address of the cycle |
| cyc_ctx | input | 3 | Context number of the cycle |
| cyc_dvma | input | 1 | 1 when a DMA master owns the cycle, 0 for the CPU |
| wr_data | input | 32 | Write data going to memory |
| wr_par | output | 4 | Parity bits to store, one for each byte lane |
| rd_data | input | 32 | Read data coming from memory |
| rd_par | input | 4 | Stored parity bits read back with `rd_data` |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 1 | Register select: 0 control, 1 error address |
| reg_be | input | 4 | Byte enables for error address writes |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Registered read data |
| nmi_req | output | 1 | Level non-maskable interrupt request |

## Verification
The hardest case to reach is a failing read that lands on the very cycle of a clearing write. The bench drives the two on the same clock and then watches the flags at zero for one cycle before the new record appears. It also drives a second clear while a deferred record is still waiting. Long random runs mix register writes that toggle the test, check and enable bits with reads whose parity is corrupted in random lanes. The bench model then sees captures, freezes and releases in orders that directed tests seldom produce.

// File: rtl/mpg_pkg.sv
package mpg_pkg;
  localparam int BYTE_W      = 8;
  localparam int DEF_LANES   = 4;
  localparam int DEF_VA_W    = 28;
  localparam int DEF_CTX_W   = 3;
  localparam int DEF_REG_W   = 32;

  // control byte bit positions (software decodes these)
  localparam int CTL_PEND_BIT = 7;
  localparam int CTL_IE_BIT   = 6;
  localparam int CTL_TEST_BIT = 5;
  localparam int CTL_CHK_BIT  = 4;

  typedef enum logic {SEL_CTRL = 1'b0, SEL_ADDR = 1'b1} reg_sel_e;
endpackage

// File: rtl/mpg_lane_parity.sv
module mpg_lane_parity
  import mpg_pkg::*;
#(
  parameter int LANES = DEF_LANES
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    wr_en,
  input  logic                    invert,
  input  logic [LANES*BYTE_W-1:0] wr_data,
  input  logic [LANES*BYTE_W-1:0] rd_data,
  input  logic [LANES-1:0]        rd_par,
  output logic [LANES-1:0]        wr_par,
  output logic [LANES-1:0]        mismatch
);
  logic [LANES-1:0] gen_par;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    // odd parity: stored bit makes the nine-bit group hold an odd count of ones
    assign gen_par[g]  = (~^wr_data[g*BYTE_W +: BYTE_W]) ^ invert;
    assign mismatch[g] = rd_par[g] ^ (~^rd_data[g*BYTE_W +: BYTE_W]);
  end

  always_ff @(posedge clk) begin
    if (rst)        wr_par <= '0;
    else if (wr_en) wr_par <= gen_par;
  end
endmodule

// File: rtl/mpg_capture.sv
module mpg_capture #(
  parameter int LANES  = 4,
  parameter int INFO_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clear,
  input  logic [LANES-1:0]  hit,
  input  logic [INFO_W-1:0] info_in,
  output logic [LANES-1:0]  flags,
  output logic [INFO_W-1:0] info,
  output logic              defer_pending
);
  logic [LANES-1:0]  defer_flags;
  logic [INFO_W-1:0] defer_info;
  logic              any_hit;
  logic              held;

  assign any_hit = |hit;
  assign held    = |flags;

  always_ff @(posedge clk) begin
    if (rst) begin
      flags         <= '0;
      info          <= '0;
      defer_pending <= 1'b0;
      defer_flags   <= '0;
      defer_info    <= '0;
    end else if (clear) begin
      flags <= '0;
      info  <= '0;
      // an error arriving with the release is parked for one cycle
      if (!defer_pending && any_hit) begin
        defer_pending <= 1'b1;
        defer_flags   <= hit;
        defer_info    <= info_in;
      end
    end else if (defer_pending) begin
      flags         <= defer_flags;
      info          <= defer_info;
      defer_pending <= 1'b0;
    end else if (!held && any_hit) begin
      flags <= hit;
      info  <= info_in;
    end
  end
endmodule

// File: rtl/mpg_ctrl_regs.sv
module mpg_ctrl_regs
  import mpg_pkg::*;
#(
  parameter int LANES  = DEF_LANES,
  parameter int INFO_W = 32,
  parameter int REG_W  = DEF_REG_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ctl_we,
  input  logic [2:0]        ctl_wbits,   // {ie, test, chk}
  input  logic              sel,
  input  logic [LANES-1:0]  flags,
  input  logic [INFO_W-1:0] info,
  output logic              ie,
  output logic              test,
  output logic              chk,
  output logic [REG_W-1:0]  rdata,
  output logic              nmi_req
);
  logic       pend;
  logic [7:0] ctl_byte;

  assign pend    = ie & (|flags);
  assign nmi_req = pend;

  always_comb begin
    ctl_byte               = '0;
    ctl_byte[LANES-1:0]    = flags;
    ctl_byte[CTL_CHK_BIT]  = chk;
    ctl_byte[CTL_TEST_BIT] = test;
    ctl_byte[CTL_IE_BIT]   = ie;
    ctl_byte[CTL_PEND_BIT] = pend;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ie    <= 1'b0;
      test  <= 1'b0;
      chk   <= 1'b0;
      rdata <= '0;
    end else begin
      if (ctl_we) {ie, test, chk} <= ctl_wbits;
      rdata <= (sel == SEL_ADDR) ? REG_W'(info) : REG_W'(ctl_byte);
    end
  end
endmodule

// File: rtl/mem_parity_guard.sv
module mem_parity_guard
  import mpg_pkg::*;
#(
  parameter int LANES = DEF_LANES,
  parameter int VA_W  = DEF_VA_W,
  parameter int CTX_W = DEF_CTX_W,
  parameter int REG_W = DEF_REG_W
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    cyc_valid,
  input  logic                    cyc_write,
  input  logic [VA_W-1:0]         cyc_vaddr,
  input  logic [CTX_W-1:0]        cyc_ctx,
  input  logic                    cyc_dvma,
  input  logic [LANES*BYTE_W-1:0] wr_data,
  output logic [LANES-1:0]        wr_par,
  input  logic [LANES*BYTE_W-1:0] rd_data,
  input  logic [LANES-1:0]        rd_par,
  input  logic                    reg_we,
  input  logic                    reg_sel,
  input  logic [REG_W/8-1:0]      reg_be,
  input  logic [REG_W-1:0]        reg_wdata,
  output logic [REG_W-1:0]        reg_rdata,
  output logic                    nmi_req
);
  localparam int INFO_W  = 1 + CTX_W + VA_W;
  localparam int BE_W    = REG_W / 8;

  logic [LANES-1:0]  mismatch;
  logic [LANES-1:0]  hit;
  logic [LANES-1:0]  err_flags;
  logic [INFO_W-1:0] err_info;
  logic [INFO_W-1:0] cyc_info;
  logic              defer_pending;
  logic              ctl_ie, ctl_test, ctl_chk;
  logic              clear;
  logic              ctl_we;
  logic              rd_cycle;
  logic              unused_bits;

  assign rd_cycle = cyc_valid & ~cyc_write;
  assign hit      = mismatch & {LANES{rd_cycle & ctl_chk}};
  assign cyc_info = {cyc_dvma, cyc_ctx, cyc_vaddr};
  assign clear    = reg_we & (reg_sel == SEL_ADDR) & reg_be[BE_W-1];
  assign ctl_we   = reg_we & (reg_sel == SEL_CTRL);

  assign unused_bits = ^{reg_wdata[REG_W-1:CTL_PEND_BIT], reg_wdata[CTL_CHK_BIT-1:0],
                         reg_be[BE_W-2:0]};

  mpg_lane_parity #(.LANES(LANES)) u_lanes (
    .clk      (clk),
    .rst      (rst),
    .wr_en    (cyc_valid & cyc_write),
    .invert   (ctl_test),
    .wr_data  (wr_data),
    .rd_data  (rd_data),
    .rd_par   (rd_par),
    .wr_par   (wr_par),
    .mismatch (mismatch)
  );

  mpg_capture #(.LANES(LANES), .INFO_W(INFO_W)) u_capture (
    .clk           (clk),
    .rst           (rst),
    .clear         (clear),
    .hit           (hit),
    .info_in       (cyc_info),
    .flags         (err_flags),
    .info          (err_info),
    .defer_pending (defer_pending)
  );

  mpg_ctrl_regs #(.LANES(LANES), .INFO_W(INFO_W), .REG_W(REG_W)) u_regs (
    .clk       (clk),
    .rst       (rst),
    .ctl_we    (ctl_we),
    .ctl_wbits (reg_wdata[CTL_IE_BIT:CTL_CHK_BIT]),
    .sel       (reg_sel),
    .flags     (err_flags),
    .info      (err_info),
    .ie        (ctl_ie),
    .test      (ctl_test),
    .chk       (ctl_chk),
    .rdata     (reg_rdata),
    .nmi_req   (nmi_req)
  );
endmodule

// File: rtl/mpg_checker.sv
module mpg_checker #(
  parameter int LANES  = 4,
  parameter int INFO_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              clear,
  input logic [LANES-1:0]  hit,
  input logic [LANES-1:0]  flags,
  input logic [INFO_W-1:0] info,
  input logic              defer_pending,
  input logic              ie,
  input logic              chk,
  input logic              nmi_req
);
  // R5: a held record does not move until released
  p_freeze_r5: assert property (@(posedge clk) disable iff (rst)
    (flags != '0 && !clear) |=> ($stable(flags) && $stable(info)));

  // R6: the release empties the flags
  p_clear_r6: assert property (@(posedge clk) disable iff (rst)
    clear |=> (flags == '0));

  // R4: first capture takes every failing lane together
  p_multi_r4: assert property (@(posedge clk) disable iff (rst)
    (flags == '0 && !defer_pending && !clear && hit != '0) |=> (flags == $past(hit)));

  // R3: no capture while checking is off
  p_chk_off_r3: assert property (@(posedge clk) disable iff (rst)
    (!chk && flags == '0 && !defer_pending) |=> (flags == '0));

  // R7: request never raised with interrupts disabled
  p_nmi_off_r7: assert property (@(posedge clk) disable iff (rst)
    !ie |-> !nmi_req);

  // R9: error on the release cycle shows up one cycle later
  p_late_r9: assert property (@(posedge clk) disable iff (rst)
    (clear && hit != '0 && !defer_pending) ##1 !clear |=> (flags == $past(hit, 2)));
endmodule

bind mem_parity_guard mpg_checker #(.LANES(LANES), .INFO_W(INFO_W)) u_chk (
  .clk           (clk),
  .rst           (rst),
  .clear         (clear),
  .hit           (hit),
  .flags         (err_flags),
  .info          (err_info),
  .defer_pending (defer_pending),
  .ie            (ctl_ie),
  .chk           (ctl_chk),
  .nmi_req       (nmi_req)
);

// File: tb/mem_parity_guard_test.sv
`timescale 1ns/1ps
module mem_parity_guard_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cyc_valid = 0, cyc_write = 0, cyc_dvma = 0;
  logic [27:0] cyc_vaddr = '0;
  logic [2:0]  cyc_ctx = '0;
  logic [31:0] wr_data = '0, rd_data = '0, reg_wdata = '0;
  logic [3:0]  rd_par = '0, reg_be = '0;
  logic        reg_we = 0, reg_sel = 0;
  logic [3:0]  wr_par;
  logic [31:0] reg_rdata;
  logic        nmi_req;

  int n_run = 0, n_fail = 0;
  bit started = 0;

  always #2.5 clk = ~clk;

  mem_parity_guard uut (
    .clk(clk), .rst(rst), .cyc_valid(cyc_valid), .cyc_write(cyc_write),
    .cyc_vaddr(cyc_vaddr), .cyc_ctx(cyc_ctx), .cyc_dvma(cyc_dvma),
    .wr_data(wr_data), .wr_par(wr_par), .rd_data(rd_data), .rd_par(rd_par),
    .reg_we(reg_we), .reg_sel(reg_sel), .reg_be(reg_be), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .nmi_req(nmi_req)
  );

  function automatic bit [3:0] opar(bit [31:0] d);
    bit [3:0] r;
    for (int i = 0; i < 4; i++) r[i] = ~^d[i*8 +: 8];
    return r;
  endfunction

  // ---------------- behavioural reference ----------------
  bit [3:0]  m_wpar, m_flags, m_dflags;
  bit        m_ie, m_test, m_chk, m_dv;
  bit [31:0] m_addr, m_daddr, m_rdata;

  always @(posedge clk) begin
    if (rst) begin
      m_wpar = 0; m_flags = 0; m_dflags = 0; m_ie = 0; m_test = 0; m_chk = 0;
      m_dv = 0; m_addr = 0; m_daddr = 0; m_rdata = 0;
    end else begin
      bit [3:0]  e;
      bit [31:0] a;
      bit        clr;
      m_rdata = reg_sel ? m_addr
                        : {24'h0, (m_ie && m_flags != 0), m_ie, m_test, m_chk, m_flags};
      e = 0;
      if (cyc_valid && !cyc_write && m_chk) e = rd_par ^ opar(rd_data);
      a = {cyc_dvma, cyc_ctx, cyc_vaddr};
      if (cyc_valid && cyc_write) m_wpar = opar(wr_data) ^ {4{m_test}};
      clr = reg_we && reg_sel && reg_be[3];
      if (clr) begin
        m_flags = 0; m_addr = 0;
        if (!m_dv && e != 0) begin m_dv = 1; m_dflags = e; m_daddr = a; end
      end else if (m_dv) begin
        m_flags = m_dflags; m_addr = m_daddr; m_dv = 0;
      end else if (m_flags == 0 && e != 0) begin
        m_flags = e; m_addr = a;
      end
      if (reg_we && !reg_sel) {m_ie, m_test, m_chk} = reg_wdata[6:4];
    end
  end

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h @%0t", tag, act, exp, $time);
    end
  endtask

  // every-cycle comparison against the model
  always @(negedge clk) begin
    if (started && !rst) begin
      check("R1 wr_par vs model", {28'h0, wr_par}, {28'h0, m_wpar});
      check("R11 reg_rdata vs model", reg_rdata, m_rdata);
      check("R7 nmi_req vs model", {31'h0, nmi_req}, {31'h0, (m_ie && m_flags != 0)});
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic step(); @(negedge clk); endtask

  task automatic idle();
    cyc_valid = 0; cyc_write = 0; reg_we = 0; reg_be = 0;
  endtask

  task automatic host_ctl(logic [7:0] v);
    reg_we = 1; reg_sel = 0; reg_wdata = {24'hABCDEF, v}; step(); idle();
  endtask

  task automatic host_addr(logic [3:0] be);
    reg_we = 1; reg_sel = 1; reg_be = be; reg_wdata = $urandom; step(); idle();
  endtask

  task automatic rd_reg(logic sel, output logic [31:0] v);
    reg_sel = sel; step(); v = reg_rdata;
  endtask

  task automatic mem_write(logic [31:0] d);
    cyc_valid = 1; cyc_write = 1; wr_data = d; step(); idle();
  endtask

  task automatic drive_read(logic [31:0] d, logic [3:0] bad, logic [27:0] va,
                            logic [2:0] cx, logic dv);
    cyc_valid = 1; cyc_write = 0; rd_data = d; rd_par = opar(d) ^ bad;
    cyc_vaddr = va; cyc_ctx = cx; cyc_dvma = dv;
  endtask

  // ---------------- watchdog ----------------
  initial begin
    #(200000 * 5);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] v;
    repeat (3) step();
    rst = 0; started = 1;
    step();
    // R10 reset state
    check("R10 nmi after reset", {31'h0, nmi_req}, 32'h0);
    check("R10 wr_par after reset", {28'h0, wr_par}, 32'h0);
    rd_reg(0, v); check("R10 control after reset", v, 32'h0);
    rd_reg(1, v); check("R10 address after reset", v, 32'h0);

    // R8 read-only bits ignore writes
    host_ctl(8'hFF);
    rd_reg(0, v); check("R8 only bits 6..4 written", v, 32'h70);

    // R1 parity on writes
    host_ctl(8'h50);
    mem_write(32'h01020304);
    check("R1 odd parity 01020304", {28'h0, wr_par}, {28'h0, opar(32'h01020304)});
    mem_write(32'h80FF0007);
    check("R1 odd parity 80FF0007", {28'h0, wr_par}, {28'h0, opar(32'h80FF0007)});

    // R2 test bit inverts
    host_ctl(8'h70);
    mem_write(32'h01020304);
    check("R2 inverted parity", {28'h0, wr_par}, {28'h0, ~opar(32'h01020304)});

    // R3 no check while disabled
    host_ctl(8'h40);
    drive_read(32'h12345678, 4'hF, 28'h0000555, 3'd1, 0); step(); idle();
    rd_reg(0, v); check("R3 check disabled no flags", v, 32'h40);

    // R4 first capture, two lanes
    host_ctl(8'h50);
    drive_read(32'hA5A50F0F, 4'b0101, 28'hABCDEF1, 3'd5, 1); step(); idle();
    rd_reg(0, v); check("R4 lanes 0 and 2 flagged", v, 32'hD5);
    rd_reg(1, v); check("R4 address fields", v, 32'hDABCDEF1);
    check("R7 nmi raised", {31'h0, nmi_req}, 32'h1);

    // R5 later error ignored
    drive_read(32'h00000000, 4'b1000, 28'h1111111, 3'd2, 0); step(); idle();
    rd_reg(0, v); check("R5 flags frozen", v, 32'hD5);
    rd_reg(1, v); check("R5 address frozen", v, 32'hDABCDEF1);

    // R6 release only with top byte
    host_addr(4'b0111);
    rd_reg(0, v); check("R6 lower-byte write no release", v, 32'hD5);
    host_addr(4'b1000);
    rd_reg(0, v); check("R6 release clears flags", v, 32'h50);
    rd_reg(1, v); check("R6 release clears address", v, 32'h0);
    check("R6 nmi dropped", {31'h0, nmi_req}, 32'h0);

    // R7 enable gates request
    host_ctl(8'h10);
    drive_read(32'hFFFF0000, 4'b0010, 28'h0000123, 3'd0, 0); step(); idle();
    rd_reg(0, v); check("R7 pending masked", v, 32'h12);
    check("R7 nmi masked", {31'h0, nmi_req}, 32'h0);
    host_ctl(8'h50);
    check("R7 nmi after enable", {31'h0, nmi_req}, 32'h1);
    rd_reg(0, v); check("R7 pending shown", v, 32'hD2);

    // R9 error on the release cycle
    drive_read(32'h13579BDF, 4'b1001, 28'h7654321, 3'd7, 1);
    reg_we = 1; reg_sel = 1; reg_be = 4'hF; step(); idle();
    check("R9 flags clear first cycle", {31'h0, nmi_req}, 32'h0);
    step();
    check("R9 capture one cycle later", {31'h0, nmi_req}, 32'h1);
    rd_reg(0, v); check("R9 deferred flags", v, 32'hD9);
    rd_reg(1, v); check("R9 deferred address", v, 32'hF7654321);

    // R11 read data shows pre-edge state
    host_addr(4'b1000);
    reg_sel = 0;
    drive_read(32'h0, 4'b0001, 28'h0000042, 3'd3, 0); step(); idle();
    check("R11 rdata before capture", reg_rdata, 32'h50);
    step();
    check("R11 rdata after capture", reg_rdata, 32'hD1);

    // random traffic against the model
    for (int k = 0; k < 3000; k++) begin
      cyc_valid = $urandom_range(0, 1);
      cyc_write = $urandom_range(0, 1);
      wr_data   = $urandom;
      rd_data   = $urandom;
      rd_par    = opar(rd_data) ^ (($urandom_range(0, 3) == 0) ? 4'($urandom) : 4'h0);
      cyc_vaddr = 28'($urandom);
      cyc_ctx   = 3'($urandom);
      cyc_dvma  = $urandom_range(0, 1);
      reg_we    = ($urandom_range(0, 7) == 0);
      reg_sel   = $urandom_range(0, 1);
      reg_be    = 4'($urandom);
      reg_wdata = $urandom;
      step();
    end
    idle();
    step();

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule